// File: doc/BRIEF.md
# Caller-ID FSK/DTMF Mode Discriminator

This block decides whether an incoming caller-ID signal carries frequency-shift-keyed data or dual-tone digits. It sits after an FSK bit recovery stage that delivers one recovered bit per bit period, marked by a one-cycle strobe, together with a flag saying a carrier is present. The block looks for an opening header in that bit stream. The header is a run of alternating ones and zeros followed by a run of steady ones. When it sees this header, it raises a mode flag that selects the FSK data path. If it never sees the header, the flag stays low and the DTMF path stays selected.

Once FSK mode is entered, an active-low data-valid output is asserted. Each strobed bit after the header is copied to a serial output. That output carries character frames, each with a low start bit, eight data bits least significant first, and a high stop bit. The header bits themselves never reach the serial output. A carrier dropout longer than a programmable number of bit times returns the block to idle. A power-down input forces the serial and data-valid outputs high and clears the decision.

Top module: `fsk_mode_sel`

## Requirements
- R1: After reset, `fsk_mode` is 0, `dv_n` is 1 and `sdata` is 1.
- R2: At least ALT_MIN (16) consecutive alternating strobed bits, followed by a run of MARK_MIN (8) consecutive strobed ones, set `fsk_mode` to 1 and `dv_n` to 0 on the clock edge that takes the final mark bit. Neither output changes on the edge that takes the seventh one.
- R3: An alternating run shorter than ALT_MIN bits, followed by ones, leaves `fsk_mode` at 0.
- R4: A stream of ones with no alternating run before it leaves `fsk_mode` at 0.
- R5: After the alternating run has been recognised, two consecutive strobed zeros before the mark run return the block to idle, and a later run of ones leaves `fsk_mode` at 0.
- R6: `sdata` stays 1 throughout the alternating run and the mark run. No header bit is forwarded.
- R7: In FSK mode, each strobed bit appears on `sdata` from the edge that takes it. A character frame is a 0 start bit, eight data bits sent least significant bit first, and a 1 stop bit.
- R8: A change of `bit_in` without `bit_stb` has no effect. A strobe taken while `carrier_ok` is 0 has no effect.
- R9: `carrier_ok` held low for up to LOSS_BITS×BIT_CYCLES clock edges keeps FSK mode. One more edge with `carrier_ok` low returns the block to idle, with `fsk_mode` 0, `dv_n` 1 and `sdata` 1.
- R10: While `pwr_dn` is 1, `sdata` and `dv_n` read 1 in the same cycle. `fsk_mode` is 0 after the next edge and stays 0 after `pwr_dn` is released.
- R11: The decision counts strobes rather than clock cycles, so uneven strobe spacing, as from a rate a few baud off nominal, gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down request, active high |
| bit_in | input | 1 | Recovered FSK bit |
| bit_stb | input | 1 | One-cycle strobe marking a valid `bit_in` |
| carrier_ok | input | 1 | FSK carrier present |
| fsk_mode | output | 1 | 1 = FSK path selected, 0 = DTMF path |
| dv_n | output | 1 | Data valid, active low |
| sdata | output | 1 | Serial character data, idles high |

## Verification
The hardest situation to reach from the ports is the carrier-loss boundary. FSK mode must survive a dropout of exactly LOSS_BITS×BIT_CYCLES edges and end one edge later. The bench shrinks BIT_CYCLES to 8 and completes a full header, then sends a start bit so that `sdata` is low. It then holds `carrier_ok` low for exactly 32 edges, restores it, and finally holds it low for 33. A second hard-to-reach path is the return to idle after a broken header. It is reached by ending a full 16-bit alternating run with a repeated zero before any mark bits.

// File: rtl/fms_pkg.sv
package fms_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEIZE = 2'd1,
    ST_DATA  = 2'd2
  } fms_state_e;
endpackage

// File: rtl/fms_run_track.sv
module fms_run_track #(
  parameter int ALT_MIN  = 16,
  parameter int MARK_MIN = 8,
  localparam int CNT_MAX = (ALT_MIN > MARK_MIN) ? ALT_MIN : MARK_MIN,
  localparam int CW      = $clog2(CNT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          stb,
  input  logic          bit_in,
  output logic [CW-1:0] alt_nxt,
  output logic [CW-1:0] ones_nxt,
  output logic          prev_bit
);
  localparam logic [CW-1:0] ALT_SAT  = CW'(ALT_MIN);
  localparam logic [CW-1:0] MARK_SAT = CW'(MARK_MIN);

  logic          prev_q, prev_d;
  logic          have_q, have_d;
  logic [CW-1:0] alt_q, alt_d;
  logic [CW-1:0] ones_q, ones_d;
  logic          upd;

  always_comb begin
    if (have_q && (bit_in != prev_q))
      alt_nxt = (alt_q >= ALT_SAT) ? ALT_SAT : alt_q + 1'b1;
    else
      alt_nxt = CW'(1);
    if (bit_in)
      ones_nxt = (ones_q >= MARK_SAT) ? MARK_SAT : ones_q + 1'b1;
    else
      ones_nxt = '0;
  end

  always_comb begin
    upd    = clr | stb;
    prev_d = clr ? 1'b0 : bit_in;
    have_d = ~clr;
    alt_d  = clr ? '0 : alt_nxt;
    ones_d = clr ? '0 : ones_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      have_q <= 1'b0;
      alt_q  <= '0;
      ones_q <= '0;
    end else if (upd) begin
      prev_q <= prev_d;
      have_q <= have_d;
      alt_q  <= alt_d;
      ones_q <= ones_d;
    end
  end

  assign prev_bit = prev_q;

  assert_alt_saturates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alt_q <= ALT_SAT);

  assert_ones_break_alternation_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_q >= CW'(2)) |-> (alt_q == CW'(1)));
endmodule

// File: rtl/fms_loss_timer.sv
module fms_loss_timer #(
  parameter int LIMIT = 32,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_ok,
  output logic loss_hit
);
  localparam logic [TW-1:0] LIM = TW'(LIMIT);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (carrier_ok)        cnt_d = '0;
    else if (cnt_q == LIM) cnt_d = cnt_q;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign loss_hit = ~carrier_ok & (cnt_q == LIM);

  assert_timer_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
endmodule

// File: rtl/fsk_mode_sel.sv
module fsk_mode_sel #(
  parameter int BIT_CYCLES = 2983,
  parameter int LOSS_BITS  = 4,
  parameter int ALT_MIN    = 16,
  parameter int MARK_MIN   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  input  logic bit_in,
  input  logic bit_stb,
  input  logic carrier_ok,
  output logic fsk_mode,
  output logic dv_n,
  output logic sdata
);
  import fms_pkg::*;

  localparam int LOSS_LIMIT = BIT_CYCLES * LOSS_BITS;
  localparam int CNT_MAX    = (ALT_MIN > MARK_MIN) ? ALT_MIN : MARK_MIN;
  localparam int CW         = $clog2(CNT_MAX + 1);

  fms_state_e    st_q, st_d;
  logic          sd_q, sd_d;
  logic          loss_hit, clr, take, prev_bit;
  logic [CW-1:0] alt_nxt, ones_nxt;

  assign clr  = pwr_dn | loss_hit;
  assign take = bit_stb & carrier_ok & ~pwr_dn;

  fms_run_track #(.ALT_MIN(ALT_MIN), .MARK_MIN(MARK_MIN)) i_track (
    .clk(clk), .rst_n(rst_n), .clr(clr), .stb(take), .bit_in(bit_in),
    .alt_nxt(alt_nxt), .ones_nxt(ones_nxt), .prev_bit(prev_bit)
  );

  fms_loss_timer #(.LIMIT(LOSS_LIMIT)) i_loss (
    .clk(clk), .rst_n(rst_n), .carrier_ok(carrier_ok), .loss_hit(loss_hit)
  );

  always_comb begin
    st_d = st_q;
    sd_d = sd_q;
    if (clr) begin
      st_d = ST_IDLE;
      sd_d = 1'b1;
    end else if (take) begin
      case (st_q)
        ST_IDLE:
          if (alt_nxt >= CW'(ALT_MIN)) st_d = ST_SEIZE;
        ST_SEIZE:
          if (ones_nxt >= CW'(MARK_MIN))  st_d = ST_DATA;
          else if (!bit_in && !prev_bit)  st_d = ST_IDLE;
        ST_DATA:
          sd_d = bit_in;
        default:
          st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      sd_q <= 1'b1;
    end else begin
      st_q <= st_d;
      sd_q <= sd_d;
    end
  end

  assign fsk_mode = (st_q == ST_DATA);
  assign dv_n     = pwr_dn | (st_q != ST_DATA);
  assign sdata    = pwr_dn | sd_q;

  assert_mode_rises_on_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsk_mode) |-> ($past(bit_in) && $past(bit_stb) && $past(carrier_ok)));

  assert_header_not_forwarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata |-> fsk_mode);

  assert_loss_returns_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    loss_hit |=> !fsk_mode);

  assert_pd_clears_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !fsk_mode);
endmodule

// File: tb/test_fsk_mode_sel.sv
module test_fsk_mode_sel;
  logic clk = 1'b0;
  logic rst_n, pwr_dn, bit_in, bit_stb, carrier_ok;
  logic fsk_mode, dv_n, sdata;
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc   = 0;
  bit   done  = 1'b0;

  always #5 clk = ~clk;

  fsk_mode_sel #(.BIT_CYCLES(8), .LOSS_BITS(4)) i_fsk_mode_sel (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .bit_in(bit_in),
    .bit_stb(bit_stb), .carrier_ok(carrier_ok),
    .fsk_mode(fsk_mode), .dv_n(dv_n), .sdata(sdata)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pwr_dn = 1'b0; bit_in = 1'b1; bit_stb = 1'b0; carrier_ok = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input int gap);
    @(negedge clk);
    bit_in = b; bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // 16 alternating bits (1 first) then 8 ones; sdata watched throughout
  task automatic send_header(input bit uneven, output bit sd_low);
    sd_low = 1'b0;
    for (int i = 0; i < 16; i++) begin
      send_bit(~i[0], uneven ? (i % 3) * 5 : 0);
      if (!sdata) sd_low = 1'b1;
    end
    for (int i = 0; i < 8; i++) begin
      send_bit(1'b1, uneven ? (i % 4) * 3 : 0);
      if (!sdata) sd_low = 1'b1;
      if (i == 6) begin
        chk("R2 mode low after 7 ones", fsk_mode, 1'b0);
        chk("R2 dv_n high after 7 ones", dv_n, 1'b1);
      end
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 fsk_mode", fsk_mode, 1'b0);
    chk("R1 dv_n", dv_n, 1'b1);
    chk("R1 sdata", sdata, 1'b1);
  endtask

  task automatic t_header_frame(input bit uneven);
    bit   sd_low;
    logic [7:0] ch;
    ch = uneven ? 8'h3C : 8'hA5;
    do_reset();
    send_header(uneven, sd_low);
    chk(uneven ? "R11 mode with uneven strobes" : "R2 mode set", fsk_mode, 1'b1);
    chk("R2 dv_n low", dv_n, 1'b0);
    chk("R6 header kept off sdata", sd_low, 1'b0);
    send_bit(1'b0, uneven ? 4 : 0);
    chk("R7 start bit", sdata, 1'b0);
    for (int i = 0; i < 8; i++) begin
      send_bit(ch[i], uneven ? i : 0);
      chk("R7 data bit LSB first", sdata, ch[i]);
    end
    send_bit(1'b1, 0);
    chk("R7 stop bit", sdata, 1'b1);
  endtask

  task automatic t_short_seize();
    do_reset();
    for (int i = 0; i < 15; i++) send_bit(~i[0], 0);
    for (int i = 0; i < 12; i++) send_bit(1'b1, 0);
    chk("R3 short alternation stays DTMF", fsk_mode, 1'b0);
    chk("R3 dv_n stays high", dv_n, 1'b1);
  endtask

  task automatic t_plain_ones();
    do_reset();
    for (int i = 0; i < 24; i++) send_bit(1'b1, 1);
    chk("R4 ones alone stay DTMF", fsk_mode, 1'b0);
  endtask

  task automatic t_broken_seize();
    do_reset();
    for (int i = 0; i < 16; i++) send_bit(~i[0], 0);
    send_bit(1'b0, 0);
    for (int i = 0; i < 10; i++) send_bit(1'b1, 0);
    chk("R5 broken header returns idle", fsk_mode, 1'b0);
    chk("R5 sdata idle", sdata, 1'b1);
  endtask

  task automatic t_ignore();
    bit sd_low;
    do_reset();
    send_header(1'b0, sd_low);
    send_bit(1'b0, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      bit_in = ~bit_in;
    end
    @(negedge clk);
    chk("R8 bit change without strobe", sdata, 1'b0);
    carrier_ok = 1'b0;
    send_bit(1'b1, 0);
    carrier_ok = 1'b1;
    @(negedge clk);
    chk("R8 strobe without carrier", sdata, 1'b0);
    chk("R8 mode kept", fsk_mode, 1'b1);
  endtask

  task automatic t_carrier();
    bit sd_low;
    do_reset();
    send_header(1'b0, sd_low);
    send_bit(1'b0, 0);
    @(negedge clk);
    carrier_ok = 1'b0;
    repeat (32) @(negedge clk);
    carrier_ok = 1'b1;
    chk("R9 dropout of 4 bit times keeps mode", fsk_mode, 1'b1);
    chk("R9 sdata kept", sdata, 1'b0);
    repeat (2) @(negedge clk);
    carrier_ok = 1'b0;
    repeat (33) @(negedge clk);
    chk("R9 longer dropout clears mode", fsk_mode, 1'b0);
    chk("R9 dv_n high", dv_n, 1'b1);
    chk("R9 sdata high", sdata, 1'b1);
    carrier_ok = 1'b1;
  endtask

  task automatic t_pdwn();
    bit sd_low;
    do_reset();
    send_header(1'b0, sd_low);
    send_bit(1'b0, 0);
    @(negedge clk);
    pwr_dn = 1'b1;
    #1;
    chk("R10 sdata high at once", sdata, 1'b1);
    chk("R10 dv_n high at once", dv_n, 1'b1);
    @(negedge clk);
    chk("R10 mode cleared", fsk_mode, 1'b0);
    pwr_dn = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 mode stays low after release", fsk_mode, 1'b0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_header_frame(1'b0);
    t_header_frame(1'b1);
    t_short_seize();
    t_plain_ones();
    t_broken_seize();
    t_ignore();
    t_carrier();
    t_pdwn();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule